// File: doc/BRIEF.md
# Serial SAR Conversion Sequencer

This block is the digital control core of a successive-approximation converter whose result leaves on a single serial data wire. Each conversion takes a fixed frame of clocks. Three things drive it: the conversion clock, an active-low start line and the answer of an external comparator. It works out the trial code for an external DAC, and it controls the track/hold switch. It runs the binary search one bit per clock and shifts each decided bit out straight away, MSB first.

How the start line is used picks the run mode. A single pulse gives one frame, after which the block returns to idle and releases the output (single-shot). If the line is lowered again before the frame ends, the next frame follows with no gap (synchronized). If the line is held low, frames repeat without end (free-run).

The frame is `PRE_CLKS + RES_W + 1` clocks long, which is 14 with the defaults. Clock 1 is the first clock after a start. Every event is taken on the rising edge. A sample "on the falling edge of clock 3" therefore appears here as hold being asserted from clock 4.

A parallel copy of the result comes with a one-clock `res_valid` strobe. A converter cannot pause its conversion, so this result stream has no ready input and no back-pressure. A consumer must take `result` in the clock where `res_valid` is high. After that, `result` holds its value until the next frame's result replaces it.

Top module: `sar_serial_seq`

## Requirements
- R1: After reset the block is idle: `sdo_oe`=0, `sdo`=0, `track`=1, `res_valid`=0, `trial_code`=0, `result`=0.
- R2: When idle and `start_n` is low at a rising edge, that edge begins clock 1 of a frame. `sdo_oe` is 1 from clock 1 to clock 14, and `sdo` is 0 in clocks 1 to 4.
- R3: `track` is 1 while idle, in clocks 1 to 3 and in clock 14. It is 0 (hold) in clocks 4 to 13.
- R4: In clock 4 `trial_code` is 1 in bit 9 only. In clock 4+k (k=0..9) the bits above bit 9-k hold the decisions already made, bit 9-k is 1 and all lower bits are 0.
- R5: A tested bit is kept only when `cmp_ge`=1, which means the input is at or above the trial level. For an input value v in 0..1023, the result is v in straight binary: the lowest input gives all zeros and full scale gives all ones.
- R6: In clocks 5 to 14, `sdo` carries result bits 9 down to 0, one bit per clock. The LSB therefore appears only in clock 14.
- R7: `res_valid` is 1 exactly in clock 14, and in that clock `result` already holds the new value.
- R8: If `start_n` is high at the edge that ends clock 14, the block goes idle and `sdo_oe` falls.
- R9: If `start_n` is low at the edge that ends clock 14, clock 1 of the next frame follows at once. `sdo_oe` stays 1 and `sdo` is 0 until the new MSB.
- R10: Once a frame has begun, changes on `start_n` before the end of clock 14 do not shorten or restart it.
- R11: While idle, `cmp_ge` has no effect: `result` and `trial_code` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start-convert |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at or above the trial level |
| trial_code | output | RES_W | Trial code to the external DAC |
| track | output | 1 | 1 = track input, 0 = hold |
| sdo | output | 1 | Serial result bit, MSB first |
| sdo_oe | output | 1 | Enable for the serial output; 0 means high-impedance |
| res_valid | output | 1 | One-clock strobe with the parallel result |
| result | output | RES_W | Parallel copy of the last result |

## Verification
Each output is registered once after the edge that causes it. `sdo_oe` rises in the clock right after the start edge. The decision made at the end of clock 4+k appears on `sdo` in clock 5+k, and the final result and `res_valid` appear in clock 14. The bench's behavioural model steps its frame position at each rising edge, using the same input values the design sees. It then compares every output 5 ns later, well before the next edge. The serial bits collected over clocks 5 to 14 are also compared with the stored analog value that the frame held.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  // Per-clock strobes from the frame controller to the datapath
  typedef struct packed {
    logic busy;   // inside a frame
    logic load;   // last pre-search clock: arm MSB trial
    logic step;   // search clock: a decision is taken at its end
    logic last;   // LSB decision clock
    logic track;  // track/hold switch
    logic endf;   // final clock of the frame
  } seq_ctl_t;
endpackage

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int PRE_CLKS = 3,
  parameter int RES_W    = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_n,
  output seq_ctl_t ctl
);
  localparam int FRAME = PRE_CLKS + RES_W + 1;
  localparam int PH_W  = $clog2(FRAME + 1);
  localparam logic [PH_W-1:0] PH_FRAME = PH_W'(FRAME);
  localparam logic [PH_W-1:0] PH_PRE   = PH_W'(PRE_CLKS);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(PRE_CLKS + RES_W);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase == '0) begin
      if (!start_n) phase <= PH_W'(1);
    end else if (phase == PH_FRAME) begin
      phase <= start_n ? '0 : PH_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  always_comb begin
    ctl.busy  = (phase != '0);
    ctl.load  = (phase == PH_PRE);
    ctl.step  = (phase > PH_PRE) && (phase <= PH_LAST);
    ctl.last  = (phase == PH_LAST);
    ctl.endf  = (phase == PH_FRAME);
    ctl.track = (phase <= PH_PRE) || (phase == PH_FRAME);
  end
endmodule

// File: rtl/sar_search_reg.sv
module sar_search_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic             last,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result
);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] trial_q, probe_q, kept;

  // bit under test survives only if the comparator says input >= trial
  assign kept = cmp_ge ? trial_q : (trial_q & ~probe_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      probe_q <= '0;
      result  <= '0;
    end else begin
      if (load) begin
        trial_q <= MSB_ONE;
        probe_q <= MSB_ONE;
      end else if (step) begin
        trial_q <= kept | (probe_q >> 1);
        probe_q <= probe_q >> 1;
      end
      if (last) result <= kept;
    end
  end

  assign trial = trial_q;
endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic step,
  input  logic cmp_ge,
  output logic sdo,
  output logic sdo_oe
);
  logic sdo_q;

  // each decision is shifted out in the clock after it is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_q <= 1'b0;
    else        sdo_q <= step & cmp_ge;
  end

  assign sdo    = sdo_q;
  assign sdo_oe = busy;
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int PRE_CLKS = 3,
  parameter int RES_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_n,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] trial_code,
  output logic             track,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             res_valid,
  output logic [RES_W-1:0] result
);
  seq_ctl_t ctl;

  sar_frame_ctl #(.PRE_CLKS(PRE_CLKS), .RES_W(RES_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .ctl(ctl)
  );

  sar_search_reg #(.RES_W(RES_W)) u_search (
    .clk(clk), .rst_n(rst_n), .load(ctl.load), .step(ctl.step),
    .last(ctl.last), .cmp_ge(cmp_ge), .trial(trial_code), .result(result)
  );

  sar_serial_out u_sout (
    .clk(clk), .rst_n(rst_n), .busy(ctl.busy), .step(ctl.step),
    .cmp_ge(cmp_ge), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign track     = ctl.track;
  assign res_valid = ctl.endf;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_n,
  input logic             track,
  input logic             sdo,
  input logic             sdo_oe,
  input logic             res_valid,
  input logic [RES_W-1:0] result
);
  AST_START_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !start_n) |=> sdo_oe); // R2
  AST_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo); // R2
  AST_IDLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> track); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R7
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && start_n) |=> !sdo_oe); // R8
  AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !start_n) |=> (sdo_oe && !sdo)); // R9
  AST_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !res_valid) |=> sdo_oe); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_oe && !$past(sdo_oe)) |-> $stable(result)); // R11
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .track(track), .sdo(sdo),
  .sdo_oe(sdo_oe), .res_valid(res_valid), .result(result)
);

// File: tb/sar_serial_seq_test.sv
`timescale 1ns/1ps
module sar_serial_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic [9:0] ain = 10'd0;
  logic cmp_ge;
  logic [9:0] trial_code, result;
  logic track, sdo, sdo_oe, res_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model state
  int mph = 0;
  int mtrial = 0;
  int mres = 0;
  int msdo = 0;
  int ain_frame = 0;
  int sr = 0;

  always #10 clk = ~clk;

  assign cmp_ge = (ain >= trial_code);

  sar_serial_seq uut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .track(track), .sdo(sdo), .sdo_oe(sdo_oe),
    .res_valid(res_valid), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // model step at each rising edge, comparison 5 ns later
  always @(posedge clk) begin
    int b;
    bit dec;
    if (!rst_n) begin
      mph = 0; mtrial = 0; mres = 0; msdo = 0;
    end else begin
      if (mph == 0) begin
        msdo = 0;
        if (!start_n) mph = 1;
      end else if (mph == 14) begin
        msdo = 0;
        mph = start_n ? 0 : 1;
      end else begin
        if (mph >= 4 && mph <= 13) begin
          b = 13 - mph;
          dec = (int'(ain) >= mtrial);
          msdo = dec;
          if (!dec) mtrial = mtrial - (1 << b);
          if (b > 0) mtrial = mtrial + (1 << (b - 1));
          else mres = mtrial;
        end else begin
          msdo = 0;
        end
        if (mph == 3) mtrial = 512;
        mph = mph + 1;
      end
    end
    #5;
    if (rst_n) begin
      chk(sdo_oe == (mph != 0), "R2 R8 R9 R10 sdo_oe", sdo_oe, mph != 0);
      chk(sdo == msdo[0], "R6 sdo", sdo, msdo);
      chk(track == (mph == 0 || mph <= 3 || mph == 14), "R3 track", track,
          (mph == 0 || mph <= 3 || mph == 14));
      chk(int'(trial_code) == mtrial, "R4 trial_code", trial_code, mtrial);
      chk(res_valid == (mph == 14), "R7 res_valid", res_valid, mph == 14);
      chk(int'(result) == mres, "R11 result", result, mres);
      if (mph == 4) begin ain_frame = ain; sr = 0; end
      if (mph >= 5 && mph <= 14) sr = ((sr << 1) | sdo) & 1023;
      if (mph >= 1 && mph <= 4) chk(sdo == 1'b0, "R2 low lead-in", sdo, 0);
      if (mph == 14) begin
        chk(sr == ain_frame, "R6 serial word", sr, ain_frame);
        chk(int'(result) == ain_frame, "R5 result value", result, ain_frame);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_ph(input int p);
    do @(negedge clk); while (mph != p);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int vals[7] = '{0, 1023, 512, 511, 1, 682, 341};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sdo_oe == 0 && sdo == 0 && track == 1 && res_valid == 0,
        "R1 reset outputs", {sdo_oe, sdo, track, res_valid}, 4'b0010);
    chk(trial_code == 0 && result == 0, "R1 reset codes", trial_code, 0);
    rst_n = 1'b1;
    idle_clocks(2);

    // single shot
    ain = 10'd700;
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    wait_ph(0);
    chk(result == 10'd700, "R5 single shot", result, 700);
    chk(sdo_oe == 0, "R8 released", sdo_oe, 0);

    // R11: comparator toggling while idle
    for (int i = 0; i < 6; i++) begin
      ain = 10'(i * 170);
      @(negedge clk);
    end
    chk(result == 10'd700, "R11 idle result hold", result, 700);
    chk(trial_code == 10'd700, "R11 idle trial hold", trial_code, 700);

    // free run across several codes
    ain = 10'd0;
    start_n = 1'b0;
    foreach (vals[i]) begin
      wait_ph(1);
      ain = vals[i];
      wait_ph(14);
    end
    start_n = 1'b1;
    wait_ph(0);

    // synchronized: relower start near the end of a frame
    ain = 10'd300;
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    wait_ph(13);
    start_n = 1'b0;
    wait_ph(2);
    chk(sdo_oe == 1, "R9 chained frame", sdo_oe, 1);
    ain = 10'd901;
    start_n = 1'b1;
    wait_ph(0);
    chk(result == 10'd901, "R9 second result", result, 901);

    // R10: start toggles mid-frame do not disturb
    ain = 10'd77;
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    wait_ph(5);
    start_n = 1'b0;
    @(negedge clk);
    start_n = 1'b1;
    wait_ph(9);
    chk(sdo_oe == 1 && mph == 9, "R10 frame continues", mph, 9);
    wait_ph(0);
    chk(result == 10'd77, "R10 result", result, 77);
    idle_clocks(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule